// File: doc/BRIEF.md
# Load-Linked Reservation Monitor

This block sits beside a core's memory request path and makes a load-linked / store-conditional pair behave as one atomic read-modify-write. It watches each request: the issuing hart, the kind of access and the byte address. It also watches a snoop port on which stores by other agents are announced. For every hart it keeps one reservation, made of a valid flag and a word address. A load-linked sets that hart's reservation. A later store-conditional may write memory only if the reservation is still valid and names the same word.

For each store-conditional the block drives the memory write enable. It also returns a status word for the destination register: 1 when the store is performed and 0 when it is dropped. Any write that reaches a reserved word, whether it comes from the local request path or from the snoop port, cancels the reservation. An exception return cancels the reservation of the hart it names.

The request path carries one request per cycle. The decision is combinational in the cycle of the request, and the reservation state changes at the next clock edge.

Top module: `llsc_rsv_monitor`

## Requirements
- R1: After reset no hart holds a reservation, so a store-conditional issued before any load-linked fails. While no request is valid, `mem_we` and `sc_valid` are 0.
- R2: `req_op` uses this encoding: 0 is a plain load, 1 a plain store, 2 a load-linked and 3 a store-conditional. A store-conditional from a hart whose reservation is valid and names the same word (address bits above bit 1, so any byte offset within the word matches) succeeds. It drives `mem_we`=1, `sc_valid`=1 and `sc_result`=1 in the request cycle.
- R3: A failing store-conditional drives `sc_valid`=1, `sc_result`=0 and `mem_we`=0.
- R4: Every store-conditional clears the issuing hart's reservation, whether it succeeds or fails, so a second store-conditional with no new load-linked fails.
- R5: A store-conditional to a word other than the reserved one fails.
- R6: A local write to a word (a plain store, or a successful store-conditional by any hart) clears the reservation of every hart that holds that word. A write to another word leaves the reservations in place.
- R7: A valid snoop store to a reserved word clears that reservation. A snoop to the same word in the same cycle as a store-conditional makes that store-conditional fail.
- R8: A new load-linked replaces the hart's earlier reservation with the new word.
- R9: An exception return clears only the named hart's reservation. In the same cycle it makes that hart's store-conditional fail and overrides that hart's load-linked.
- R10: A plain store always drives `mem_we`=1 with `sc_valid`=0. Plain loads and load-linked accesses drive `mem_we`=0 and `sc_valid`=0.
- R11: A load-linked that arrives in the same cycle as a snoop to the same word still establishes its reservation.
- R12: Reservations are private to each hart: one hart's load-linked, store-conditional or plain load does not change another hart's reservation, and plain loads never change any reservation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is present this cycle |
| req_hart | input | HART_W | Issuing hart index |
| req_op | input | 2 | Access kind (0 load, 1 store, 2 load-linked, 3 store-conditional) |
| req_addr | input | ADDR_W | Byte address of the request |
| snp_valid | input | 1 | A store from another agent is reported |
| snp_addr | input | ADDR_W | Byte address of the snooped store |
| eret_valid | input | 1 | Exception return for one hart |
| eret_hart | input | HART_W | Hart taking the exception return |
| mem_we | output | 1 | Write enable toward memory for this request |
| sc_valid | output | 1 | This request is a store-conditional and a status is returned |
| sc_result | output | XLEN | Status for the destination register: 1 success, 0 failure |

## Verification
The hardest states to reach are the coincidences: a snoop, an exception return or another hart's store that lands on the reserved word in the very cycle of a store-conditional or a load-linked. Random traffic rarely lines these up. Directed steps therefore force each pairing, including a snoop that meets a load-linked and a snoop that meets a store-conditional. The bench then runs a random phase over only four words and two harts, so that address collisions are frequent. A behavioural model compares every cycle against the design throughout.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_LINK  = 2'd2,
    OP_COND  = 2'd3
  } mem_op_e;
endpackage

// File: rtl/llsc_rsv_slot.sv
// One hart's reservation: valid flag plus reserved word address.
module llsc_rsv_slot #(
  parameter int WORD_W = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              drop_i,      // exception return for this hart
  input  logic              link_i,      // own load-linked
  input  logic              own_cond_i,  // own store-conditional
  input  logic [WORD_W-1:0] req_word_i,
  input  logic              wr_i,        // local write performed this cycle
  input  logic              snp_i,
  input  logic [WORD_W-1:0] snp_word_i,
  output logic              vld_o,
  output logic [WORD_W-1:0] word_o
);
  logic              vld_q, vld_d;
  logic [WORD_W-1:0] word_q;
  logic              word_en;
  logic              wr_hit, snp_hit;

  assign wr_hit  = wr_i  && (word_q == req_word_i);
  assign snp_hit = snp_i && (word_q == snp_word_i);
  assign word_en = link_i && !drop_i;

  always_comb begin
    vld_d = vld_q;
    if (drop_i)                 vld_d = 1'b0;
    else if (link_i)            vld_d = 1'b1;
    else if (own_cond_i)        vld_d = 1'b0;
    else if (wr_hit || snp_hit) vld_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      word_q <= '0;
    end else begin
      vld_q <= vld_d;
      if (word_en) word_q <= req_word_i;
    end
  end

  assign vld_o  = vld_q;
  assign word_o = word_q;
endmodule

// File: rtl/llsc_cond_eval.sv
// Decides whether the current store-conditional may write.
module llsc_cond_eval #(
  parameter int NUM_HARTS = 2,
  parameter int HART_W    = 1,
  parameter int WORD_W    = 30
) (
  input  logic [NUM_HARTS-1:0]             vld_i,
  input  logic [NUM_HARTS-1:0][WORD_W-1:0] word_i,
  input  logic                             cond_i,
  input  logic [HART_W-1:0]                hart_i,
  input  logic [WORD_W-1:0]                req_word_i,
  input  logic                             snp_i,
  input  logic [WORD_W-1:0]                snp_word_i,
  input  logic                             drop_i,
  input  logic [HART_W-1:0]                drop_hart_i,
  output logic                             ok_o
);
  logic              sel_vld;
  logic [WORD_W-1:0] sel_word;

  always_comb begin
    sel_vld  = 1'b0;
    sel_word = '0;
    for (int k = 0; k < NUM_HARTS; k++) begin
      if (hart_i == HART_W'(k)) begin
        sel_vld  = vld_i[k];
        sel_word = word_i[k];
      end
    end
  end

  assign ok_o = cond_i && sel_vld && (sel_word == req_word_i)
             && !(snp_i && (snp_word_i == req_word_i))
             && !(drop_i && (drop_hart_i == hart_i));
endmodule

// File: rtl/llsc_rsv_monitor.sv
module llsc_rsv_monitor #(
  parameter int NUM_HARTS  = 2,
  parameter int ADDR_W     = 32,
  parameter int XLEN       = 32,
  parameter int WORD_BYTES = 4,
  localparam int HART_W    = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1,
  localparam int OFFS_W    = $clog2(WORD_BYTES),
  localparam int WORD_W    = ADDR_W - OFFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [HART_W-1:0] req_hart,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              snp_valid,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic              eret_valid,
  input  logic [HART_W-1:0] eret_hart,
  output logic              mem_we,
  output logic              sc_valid,
  output logic [XLEN-1:0]   sc_result
);
  import llsc_pkg::*;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  mem_op_e                        op;
  logic [WORD_W-1:0]              req_word, snp_word;
  logic                           is_store, is_link, is_cond, cond_ok, wr_any;
  logic [NUM_HARTS-1:0]           slot_vld;
  logic [NUM_HARTS-1:0][WORD_W-1:0] slot_word;

  assign op       = mem_op_e'(req_op);
  assign req_word = req_addr[ADDR_W-1:OFFS_W];
  assign snp_word = snp_addr[ADDR_W-1:OFFS_W];
  assign is_store = req_valid && (op == OP_STORE);
  assign is_link  = req_valid && (op == OP_LINK);
  assign is_cond  = req_valid && (op == OP_COND);

  llsc_cond_eval #(
    .NUM_HARTS(NUM_HARTS), .HART_W(HART_W), .WORD_W(WORD_W)
  ) u_eval (
    .vld_i(slot_vld), .word_i(slot_word), .cond_i(is_cond), .hart_i(req_hart),
    .req_word_i(req_word), .snp_i(snp_valid), .snp_word_i(snp_word),
    .drop_i(eret_valid), .drop_hart_i(eret_hart), .ok_o(cond_ok)
  );

  assign wr_any = is_store || cond_ok;

  for (genvar g = 0; g < NUM_HARTS; g++) begin : g_slot
    logic mine;
    assign mine = (req_hart == HART_W'(g));
    llsc_rsv_slot #(.WORD_W(WORD_W)) u_slot (
      .clk        (clk),
      .rst_n      (rst_int_n),
      .drop_i     (eret_valid && (eret_hart == HART_W'(g))),
      .link_i     (is_link && mine),
      .own_cond_i (is_cond && mine),
      .req_word_i (req_word),
      .wr_i       (wr_any),
      .snp_i      (snp_valid),
      .snp_word_i (snp_word),
      .vld_o      (slot_vld[g]),
      .word_o     (slot_word[g])
    );
  end

  assign mem_we    = wr_any;
  assign sc_valid  = is_cond;
  assign sc_result = XLEN'(cond_ok);
endmodule

// File: rtl/llsc_rsv_monitor_chk.sv
module llsc_rsv_monitor_chk #(
  parameter int NUM_HARTS  = 2,
  parameter int ADDR_W     = 32,
  parameter int XLEN       = 32,
  parameter int WORD_BYTES = 4,
  localparam int HART_W    = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1,
  localparam int OFFS_W    = $clog2(WORD_BYTES)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [HART_W-1:0] req_hart,
  input logic [1:0]        req_op,
  input logic [ADDR_W-1:0] req_addr,
  input logic              snp_valid,
  input logic [ADDR_W-1:0] snp_addr,
  input logic              eret_valid,
  input logic [HART_W-1:0] eret_hart,
  input logic              mem_we,
  input logic              sc_valid,
  input logic [XLEN-1:0]   sc_result
);
  logic cond_now;
  assign cond_now = req_valid && (req_op == 2'd3);

  p_fail_no_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_valid && (sc_result == '0)) |-> !mem_we);

  p_status_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sc_valid |-> (sc_result[XLEN-1:1] == '0));

  p_store_writes_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'd1) |-> (mem_we && !sc_valid));

  p_load_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_op == 2'd0 || req_op == 2'd2)) |-> (!mem_we && !sc_valid));

  p_second_cond_fails_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_now && $past(cond_now) && $past(req_hart) == req_hart
     && $past(eret_valid) == 1'b0) |-> (sc_result[0] == 1'b0));

  p_snoop_kills_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_now && snp_valid
     && snp_addr[ADDR_W-1:OFFS_W] == req_addr[ADDR_W-1:OFFS_W]) |-> !mem_we);

  p_eret_kills_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_now && eret_valid && eret_hart == req_hart) |-> (sc_result[0] == 1'b0));
endmodule

bind llsc_rsv_monitor llsc_rsv_monitor_chk #(
  .NUM_HARTS(NUM_HARTS), .ADDR_W(ADDR_W), .XLEN(XLEN), .WORD_BYTES(WORD_BYTES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_hart(req_hart),
  .req_op(req_op), .req_addr(req_addr), .snp_valid(snp_valid),
  .snp_addr(snp_addr), .eret_valid(eret_valid), .eret_hart(eret_hart),
  .mem_we(mem_we), .sc_valid(sc_valid), .sc_result(sc_result)
);

// File: tb/llsc_rsv_monitor_bench.sv
module llsc_rsv_monitor_bench;
  localparam int NH = 2;
  localparam int AW = 32;
  localparam int XL = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, snp_valid, eret_valid;
  logic [0:0]    req_hart, eret_hart;
  logic [1:0]    req_op;
  logic [AW-1:0] req_addr, snp_addr;
  logic          mem_we, sc_valid;
  logic [XL-1:0] sc_result;

  int checks = 0;
  int errors = 0;

  // reference reservations
  bit      m_vld [NH];
  longint  m_word[NH];

  always #2 clk = ~clk;

  llsc_rsv_monitor u_llsc_rsv_monitor (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_hart(req_hart),
    .req_op(req_op), .req_addr(req_addr), .snp_valid(snp_valid),
    .snp_addr(snp_addr), .eret_valid(eret_valid), .eret_hart(eret_hart),
    .mem_we(mem_we), .sc_valid(sc_valid), .sc_result(sc_result)
  );

  task automatic check(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // one cycle: drive at negedge, compare before the next rising edge,
  // then advance the model. exp_sc: -1 = no directed expectation.
  task automatic step(string tag, bit v, int h, int op, longint a,
                      bit sv, longint sa, bit ev, int eh, int exp_sc);
    longint w, sw;
    bit ok, we;
    @(negedge clk);
    req_valid = v; req_hart = h[0:0]; req_op = op[1:0]; req_addr = a[AW-1:0];
    snp_valid = sv; snp_addr = sa[AW-1:0]; eret_valid = ev; eret_hart = eh[0:0];
    #1;
    w  = a >> 2;
    sw = sa >> 2;
    ok = v && op == 3 && m_vld[h] && m_word[h] == w && !(sv && sw == w)
         && !(ev && eh == h);
    we = v && (op == 1 || ok);
    check(tag, "mem_we", mem_we, we);
    check(tag, "sc_valid", sc_valid, v && op == 3);
    check(tag, "sc_result", sc_result, ok);
    if (exp_sc >= 0) check(tag, "directed sc_result", sc_result, exp_sc);
    for (int k = 0; k < NH; k++) begin
      if (ev && eh == k)                  m_vld[k] = 0;
      else if (v && op == 2 && h == k)  begin m_vld[k] = 1; m_word[k] = w; end
      else if (v && op == 3 && h == k)    m_vld[k] = 0;
      else if (we && m_word[k] == w)      m_vld[k] = 0;
      else if (sv && m_word[k] == sw)     m_vld[k] = 0;
    end
  endtask

  task automatic req(string tag, int h, int op, longint a, int exp_sc);
    step(tag, 1, h, op, a, 0, 0, 0, 0, exp_sc);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < NH; k++) begin m_vld[k] = 0; m_word[k] = 0; end
    rst_n = 1'b0; req_valid = 0; req_hart = 0; req_op = 0; req_addr = 0;
    snp_valid = 0; snp_addr = 0; eret_valid = 0; eret_hart = 0;
    repeat (3) @(negedge clk);
    #1;
    check("R1", "reset mem_we", mem_we, 0);
    check("R1", "reset sc_valid", sc_valid, 0);
    rst_n = 1'b1;
    repeat (4) step("R1", 0, 0, 0, 0, 0, 0, 0, 0, -1);
    req("R1", 0, 3, 'h100, 0);                       // no reservation yet
    // R2 success, byte offset inside word
    req("R2", 0, 2, 'h100, -1);
    req("R2", 0, 3, 'h103, 1);
    // R4 second conditional fails
    req("R4", 0, 3, 'h100, 0);
    // R5 different word
    req("R5", 0, 2, 'h200, -1);
    req("R5", 0, 3, 'h204, 0);
    // R3 failed conditional does not write, R4 cleared after failure
    req("R3", 0, 2, 'h200, -1);
    req("R3", 0, 3, 'h300, 0);
    req("R4", 0, 3, 'h200, 0);
    // R6 other hart's store clears, store elsewhere does not
    req("R6", 0, 2, 'h40, -1);
    req("R6", 1, 1, 'h80, -1);
    req("R6", 0, 3, 'h40, 1);
    req("R6", 0, 2, 'h40, -1);
    req("R6", 1, 1, 'h42, -1);
    req("R6", 0, 3, 'h40, 0);
    // R6 successful conditional by one hart kills the other's
    req("R6", 0, 2, 'h60, -1);
    req("R6", 1, 2, 'h60, -1);
    req("R6", 1, 3, 'h60, 1);
    req("R6", 0, 3, 'h60, 0);
    // R7 snoop clears; snoop same cycle as conditional
    req("R7", 0, 2, 'h70, -1);
    step("R7", 0, 0, 0, 0, 1, 'h71, 0, 0, -1);
    req("R7", 0, 3, 'h70, 0);
    req("R7", 0, 2, 'h70, -1);
    step("R7", 0, 0, 0, 0, 1, 'h90, 0, 0, -1);
    step("R7", 1, 0, 3, 'h70, 1, 'h70, 0, 0, 0);
    // R11 snoop same cycle as load-linked
    step("R11", 1, 1, 2, 'hA0, 1, 'hA0, 0, 0, -1);
    req("R11", 1, 3, 'hA0, 1);
    // R8 replacement
    req("R8", 1, 2, 'hB0, -1);
    req("R8", 1, 2, 'hC0, -1);
    req("R8", 1, 3, 'hB0, 0);
    req("R8", 1, 2, 'hB0, -1);
    req("R8", 1, 2, 'hC0, -1);
    req("R8", 1, 3, 'hC0, 1);
    // R9 exception return: only named hart, same-cycle cases
    req("R9", 0, 2, 'hD0, -1);
    req("R9", 1, 2, 'hE0, -1);
    step("R9", 0, 0, 0, 0, 0, 0, 1, 0, -1);
    req("R9", 0, 3, 'hD0, 0);
    req("R9", 1, 3, 'hE0, 1);
    req("R9", 0, 2, 'hD0, -1);
    step("R9", 1, 0, 3, 'hD0, 0, 0, 1, 0, 0);
    step("R9", 1, 1, 2, 'hE0, 0, 0, 1, 1, -1);
    req("R9", 1, 3, 'hE0, 0);
    // R10 / R12 loads do not disturb, harts are private
    req("R12", 0, 2, 'hF0, -1);
    req("R12", 1, 0, 'hF0, -1);
    req("R12", 0, 0, 'hF0, -1);
    req("R12", 1, 2, 'h10, -1);
    req("R12", 1, 3, 'h10, 1);
    req("R12", 0, 3, 'hF0, 1);
    req("R10", 1, 1, 'h500, -1);
    req("R10", 0, 0, 'h500, -1);
    // random phase over four words
    for (int i = 0; i < 3000; i++) begin
      step("R2,R3,R6,R7,R9", $urandom_range(0, 3) != 0, $urandom_range(0, 1),
           $urandom_range(0, 3), $urandom_range(0, 15),
           $urandom_range(0, 5) == 0, $urandom_range(0, 15),
           $urandom_range(0, 15) == 0, $urandom_range(0, 1), -1);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule